// File: doc/BRIEF.md
# Predicated Move-Slot Decoder

This block decodes one instruction word of a transport-triggered processor. The word packs several move slots that all issue in the same cycle. Each slot names a guard, says whether its source is a short immediate, and gives a source code and a destination address. For every slot the decoder evaluates the guard against a small file of one-bit predicate registers and picks the value to transport. That value is a source word, the program counter, the long-immediate register or a sign-extended short constant. The decoder then emits a registered bus transfer: data, destination and enable.

Predicate registers are loaded by ordinary moves whose destination falls in the top predicate address range, so a compare result moved there can guard later moves. Predicate 0 always reads true and makes unguarded moves. A separate long-immediate register is loaded from a 32-bit constant that travels next to the instruction word. Jumps, branches and calls are ordinary moves into or out of the program-counter ports, so they need no special handling here. When two enabled slots hit the same destination in one word, the lower-numbered slot keeps it and a conflict flag is raised.

Top module: `move_decoder`

## Requirements
- R1: A synchronous active-low reset clears all enables, all bus data and destinations, the conflict flag and predicates 1 to 7 (false).
- R2: Slot i sits at instr[i*17 +: 17] with invert bit 16, predicate index 15:13, immediate flag 12, source 11:6 and destination 5:0. A slot's transfer appears on out_en[i], out_dst[i*6 +: 6] and out_data[i*32 +: 32] one clock after the word is presented.
- R3: With the immediate flag 0, source codes 0 to 7 select word k of src_words, code 62 selects pc_value, code 63 selects the long-immediate value, and any other code transports zero.
- R4: With the immediate flag 1, the 6-bit source field is sign-extended to 32 bits.
- R5: limm_load stores limm_value in the long-immediate register. A slot that reads code 63 in the same word sees the new value, and later words see the stored value.
- R6: A slot is enabled only when issue is 1 and its predicate value XOR its invert bit is 1. Guard code 0 always enables and guard code 8 never does. A disabled slot shows enable 0 with data and destination 0.
- R7: An enabled transfer to destination 56+k (k = 1..7) sets predicate k to bit 0 of its data, and the next word sees the new value. A write to destination 56 (predicate 0) has no effect.
- R8: When several enabled slots share a destination, only the lowest-numbered one is enabled and conflict is 1 for that cycle. Otherwise conflict is 0.
- R9: With issue 0, no slot is enabled and no predicate is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction word valid this cycle |
| instr | input | 68 | Four move slots of 17 bits |
| src_words | input | 256 | Eight 32-bit register or port read values |
| pc_value | input | 32 | Current program counter, source code 62 |
| limm_load | input | 1 | Load long-immediate register |
| limm_value | input | 32 | Long constant carried with the word |
| out_en | output | 4 | Per-slot transfer enable |
| out_dst | output | 24 | Per-slot destination address |
| out_data | output | 128 | Per-slot transported value |
| conflict | output | 1 | Destination collision in the last word |

## Verification
Every bus output and the conflict flag are due one clock after the word is presented. The bench drives on the falling edge and reads back on the next falling edge, after exactly one rising edge. A predicate write affects the guard of the word issued one cycle later, so its result shows two falling edges after the writing word. The stimulus table is therefore ordered as a sequence, and each row's expectation assumes the predicates left by the rows before it. Long-immediate reads are checked in the loading word, through the bypass, and in the following word, from the register.

// File: rtl/move_pkg.sv
// Shared definitions for the move-slot decoder.
// Assumes 6-bit source codes, with the two top codes reserved for PC and long immediate.
package move_pkg;
    localparam int unsigned DEF_DW     = 32;
    localparam int unsigned DEF_SRC_W  = 6;
    localparam int unsigned DEF_DST_W  = 6;
    localparam int unsigned DEF_NBOOL  = 8;
    localparam int unsigned DEF_NSRC   = 8;
    localparam int unsigned DEF_NSLOTS = 4;

    // Where a slot's value comes from.
    typedef enum logic [2:0] {
        SK_REG  = 3'd0,
        SK_PC   = 3'd1,
        SK_LIMM = 3'd2,
        SK_IMM  = 3'd3,
        SK_NONE = 3'd4
    } src_kind_e;
endpackage

// File: rtl/mv_pred_file.sv
// Predicate register file: entry 0 is constant true, entries 1..NBOOL-1 are flops.
// Assumes at most one write per entry per cycle (guaranteed by the arbiter upstream).
module mv_pred_file #(
    parameter int unsigned NBOOL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBOOL-1:1] wr_en,
    input  logic [NBOOL-1:1] wr_val,
    output logic [NBOOL-1:0] bits
);
    logic [NBOOL-1:1] bits_q;

    // Update written predicates; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            for (int k = 1; k < NBOOL; k++) begin
                if (wr_en[k]) bits_q[k] <= wr_val[k];
            end
        end
    end

    assign bits = {bits_q, 1'b1};
endmodule

// File: rtl/mv_slot_source.sv
// Selects the value one slot transports: short immediate, source word, PC,
// long immediate, or zero for an unused code. Purely combinational.
module mv_slot_source
    import move_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned SRC_W = 6,
    parameter int unsigned NSRC  = 8
) (
    input  logic               imm_flag,
    input  logic [SRC_W-1:0]   src,
    input  logic [NSRC*DW-1:0] src_words,
    input  logic [DW-1:0]      pc_value,
    input  logic [DW-1:0]      limm_value,
    output logic [DW-1:0]      data
);
    localparam int unsigned SEL_W     = $clog2(NSRC);
    localparam logic [SRC_W-1:0] CODE_LIMM = SRC_W'((1 << SRC_W) - 1);
    localparam logic [SRC_W-1:0] CODE_PC   = SRC_W'((1 << SRC_W) - 2);

    src_kind_e kind;

    // Classify the source field.
    always_comb begin
        if (imm_flag)                    kind = SK_IMM;
        else if (src < SRC_W'(NSRC))     kind = SK_REG;
        else if (src == CODE_PC)         kind = SK_PC;
        else if (src == CODE_LIMM)       kind = SK_LIMM;
        else                             kind = SK_NONE;
    end

    // Drive the chosen value.
    always_comb begin
        case (kind)
            SK_IMM:  data = {{(DW-SRC_W){src[SRC_W-1]}}, src};
            SK_REG:  data = src_words[src[SEL_W-1:0]*DW +: DW];
            SK_PC:   data = pc_value;
            SK_LIMM: data = limm_value;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/mv_dest_arbiter.sv
// Resolves destination collisions among enabled slots: the lowest index keeps
// the destination. Assumes req already includes guard and issue.
module mv_dest_arbiter #(
    parameter int unsigned NSLOTS = 4,
    parameter int unsigned DST_W  = 6
) (
    input  logic [NSLOTS-1:0]       req,
    input  logic [NSLOTS*DST_W-1:0] dst,
    output logic [NSLOTS-1:0]       grant,
    output logic                    conflict
);
    // Drop any slot whose destination a lower enabled slot already owns.
    always_comb begin
        for (int i = 0; i < NSLOTS; i++) begin
            grant[i] = req[i];
            for (int j = 0; j < i; j++) begin
                if (req[j] && dst[j*DST_W +: DST_W] == dst[i*DST_W +: DST_W])
                    grant[i] = 1'b0;
            end
        end
    end

    assign conflict = |(req & ~grant);
endmodule

// File: rtl/move_decoder.sv
// Multi-slot guarded move decoder. Each slot: guard (invert + predicate index),
// immediate flag, source, destination. Produces registered per-slot transfers,
// updates predicates from moves into the predicate address range, and holds a
// long-immediate register with same-cycle bypass.
module move_decoder
    import move_pkg::*;
#(
    parameter int unsigned NSLOTS = DEF_NSLOTS,
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned SRC_W  = DEF_SRC_W,
    parameter int unsigned DST_W  = DEF_DST_W,
    parameter int unsigned NBOOL  = DEF_NBOOL,
    parameter int unsigned NSRC   = DEF_NSRC,
    localparam int unsigned BIDX_W = $clog2(NBOOL),
    localparam int unsigned SLOT_W = BIDX_W + 1 + 1 + SRC_W + DST_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic [NSLOTS*SLOT_W-1:0] instr,
    input  logic [NSRC*DW-1:0]       src_words,
    input  logic [DW-1:0]            pc_value,
    input  logic                     limm_load,
    input  logic [DW-1:0]            limm_value,
    output logic [NSLOTS-1:0]        out_en,
    output logic [NSLOTS*DST_W-1:0]  out_dst,
    output logic [NSLOTS*DW-1:0]     out_data,
    output logic                     conflict
);
    localparam int unsigned BOOL_BASE = (1 << DST_W) - NBOOL;

    logic [DW-1:0]            limm_q;
    logic [DW-1:0]            limm_now;
    logic [NBOOL-1:0]         pbits;
    logic [NSLOTS-1:0]        req;
    logic [NSLOTS-1:0]        grant;
    logic                     conflict_d;
    logic [NSLOTS*DST_W-1:0]  dst_flat;
    logic [DW-1:0]            data_a [NSLOTS];
    logic [NBOOL-1:1]         pw_en;
    logic [NBOOL-1:1]         pw_val;

    // Long-immediate register: load when requested.
    always_ff @(posedge clk) begin
        if (!rst_n)         limm_q <= '0;
        else if (limm_load) limm_q <= limm_value;
    end

    assign limm_now = limm_load ? limm_value : limm_q;

    // Per-slot field decode, guard evaluation and source selection.
    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        logic [SLOT_W-1:0] fld;
        logic              g_inv;
        logic [BIDX_W-1:0] g_idx;
        assign fld   = instr[i*SLOT_W +: SLOT_W];
        assign g_inv = fld[SLOT_W-1];
        assign g_idx = fld[SLOT_W-2 -: BIDX_W];
        assign dst_flat[i*DST_W +: DST_W] = fld[DST_W-1:0];
        assign req[i] = issue && (pbits[g_idx] ^ g_inv);

        mv_slot_source #(.DW(DW), .SRC_W(SRC_W), .NSRC(NSRC)) u_src (
            .imm_flag   (fld[SRC_W+DST_W]),
            .src        (fld[DST_W +: SRC_W]),
            .src_words  (src_words),
            .pc_value   (pc_value),
            .limm_value (limm_now),
            .data       (data_a[i])
        );
    end

    mv_dest_arbiter #(.NSLOTS(NSLOTS), .DST_W(DST_W)) u_arb (
        .req      (req),
        .dst      (dst_flat),
        .grant    (grant),
        .conflict (conflict_d)
    );

    // Predicate writes from granted moves into the predicate address range.
    always_comb begin
        pw_en  = '0;
        pw_val = '0;
        for (int k = 1; k < NBOOL; k++) begin
            for (int i = 0; i < NSLOTS; i++) begin
                if (grant[i] && dst_flat[i*DST_W +: DST_W] == DST_W'(BOOL_BASE + k)) begin
                    pw_en[k]  = 1'b1;
                    pw_val[k] = data_a[i][0];
                end
            end
        end
    end

    mv_pred_file #(.NBOOL(NBOOL)) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pw_en),
        .wr_val (pw_val),
        .bits   (pbits)
    );

    // Register the bus transfers; disabled slots show zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= '0;
            out_dst  <= '0;
            out_data <= '0;
            conflict <= 1'b0;
        end else begin
            out_en   <= grant;
            conflict <= conflict_d;
            for (int i = 0; i < NSLOTS; i++) begin
                out_dst[i*DST_W +: DST_W] <= grant[i] ? dst_flat[i*DST_W +: DST_W] : '0;
                out_data[i*DW +: DW]      <= grant[i] ? data_a[i] : '0;
            end
        end
    end
endmodule

// File: rtl/mv_checker.sv
// Temporal checks for move_decoder, attached by bind below.
module mv_checker #(
    parameter int unsigned NSLOTS = 4,
    parameter int unsigned DW     = 32,
    parameter int unsigned SRC_W  = 6,
    parameter int unsigned DST_W  = 6,
    parameter int unsigned SLOT_W = 17
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     issue,
    input logic [NSLOTS*SLOT_W-1:0] instr,
    input logic                     limm_load,
    input logic [DW-1:0]            limm_value,
    input logic [DW-1:0]            limm_q,
    input logic [NSLOTS-1:0]        out_en,
    input logic [NSLOTS*DST_W-1:0]  out_dst,
    input logic [NSLOTS*DW-1:0]     out_data
);
    localparam int unsigned GW = SLOT_W - 1 - SRC_W - DST_W;
    localparam logic [GW-1:0] G_ALWAYS = '0;
    localparam logic [GW-1:0] G_NEVER  = GW'(1) << (GW - 1);

    // R9: no transfers for a word that was not issued.
    a_r9_idle_no_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> out_en == '0);

    // R5: long-immediate register captures the loaded constant.
    a_r5_limm_capture: assert property (@(posedge clk) disable iff (!rst_n)
        limm_load |=> limm_q == $past(limm_value));

    // R4: slot 0 unguarded short immediate arrives sign-extended.
    a_r4_short_imm_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr[SLOT_W-1 -: GW] == G_ALWAYS && instr[SRC_W+DST_W])
        |=> out_data[DW-1:0] == {{(DW-SRC_W){$past(instr[DST_W+SRC_W-1])}},
                                 $past(instr[DST_W +: SRC_W])});

    // R6: slot 0 with the always guard is always enabled.
    a_r6_always_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr[SLOT_W-1 -: GW] == G_ALWAYS) |=> out_en[0]);

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot_chk
        // R6: the never guard suppresses the slot.
        a_r6_never_guard: assert property (@(posedge clk) disable iff (!rst_n)
            instr[i*SLOT_W + SLOT_W-1 -: GW] == G_NEVER |=> !out_en[i]);
        for (genvar j = i + 1; j < NSLOTS; j++) begin : g_pair
            // R8: no two live transfers share a destination.
            a_r8_unique_dst: assert property (@(posedge clk) disable iff (!rst_n)
                (out_en[i] && out_en[j]) |->
                out_dst[i*DST_W +: DST_W] != out_dst[j*DST_W +: DST_W]);
        end
    end
endmodule

bind move_decoder mv_checker #(
    .NSLOTS(NSLOTS), .DW(DW), .SRC_W(SRC_W), .DST_W(DST_W), .SLOT_W(SLOT_W)
) u_mv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .instr      (instr),
    .limm_load  (limm_load),
    .limm_value (limm_value),
    .limm_q     (limm_q),
    .out_en     (out_en),
    .out_dst    (out_dst),
    .out_data   (out_data)
);

// File: tb/test_move_decoder.sv
`timescale 1ns/1ps
module test_move_decoder;
    localparam int NV = 11;
    localparam logic [16:0] NOP = {4'd8, 1'b0, 6'd0, 6'd0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [67:0]  instr = {NOP, NOP, NOP, NOP};
    logic [255:0] src_words;
    logic [31:0]  pc_value = 32'h0000_0400;
    logic         limm_load = 1'b0;
    logic [31:0]  limm_value = '0;
    logic [3:0]   out_en;
    logic [23:0]  out_dst;
    logic [127:0] out_data;
    logic         conflict;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    move_decoder i_move_decoder (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .src_words(src_words), .pc_value(pc_value), .limm_load(limm_load),
        .limm_value(limm_value), .out_en(out_en), .out_dst(out_dst),
        .out_data(out_data), .conflict(conflict)
    );

    // Row: {slot3, slot2, slot1, slot0, exp_en, exp_conflict, exp_data_slot0}
    // Slot: {guard[3:0], imm, src[5:0], dst[5:0]}; source word k = A000000k.
    localparam logic [104:0] VECS [NV] = '{
        // R3: source word 3 to dst 10
        {NOP, NOP, NOP, {4'd0, 1'b0, 6'd3, 6'd10}, 4'b0001, 1'b0, 32'hA000_0003},
        // R4: short immediate -1
        {NOP, NOP, NOP, {4'd0, 1'b1, 6'h3F, 6'd5}, 4'b0001, 1'b0, 32'hFFFF_FFFF},
        // R4: short immediate +31
        {NOP, NOP, NOP, {4'd0, 1'b1, 6'h1F, 6'd5}, 4'b0001, 1'b0, 32'h0000_001F},
        // R8: slots 0 and 1 both to dst 20
        {NOP, NOP, {4'd0, 1'b0, 6'd4, 6'd20}, {4'd0, 1'b0, 6'd2, 6'd20}, 4'b0001, 1'b1, 32'hA000_0002},
        // R1/R6: predicate 3 false since reset; slot 1 writes predicate 3 = 1 (R7)
        {NOP, NOP, {4'd0, 1'b1, 6'd1, 6'd59}, {4'd3, 1'b0, 6'd1, 6'd7}, 4'b0010, 1'b0, 32'h0},
        // R7: predicate 3 now true; inverted guard on it disabled (R6)
        {NOP, NOP, {4'd11, 1'b0, 6'd2, 6'd8}, {4'd3, 1'b0, 6'd1, 6'd7}, 4'b0001, 1'b0, 32'hA000_0001},
        // R3: program counter as source (call)
        {NOP, NOP, NOP, {4'd0, 1'b0, 6'd62, 6'd12}, 4'b0001, 1'b0, 32'h0000_0400},
        // R6: never guard on slot 0, slot 2 live
        {NOP, {4'd0, 1'b0, 6'd5, 6'd30}, NOP, {4'd8, 1'b0, 6'd1, 6'd9}, 4'b0100, 1'b0, 32'h0},
        // R7: clear predicate 3
        {NOP, NOP, NOP, {4'd0, 1'b1, 6'd0, 6'd59}, 4'b0001, 1'b0, 32'h0},
        // R7: guard on cleared predicate 3
        {NOP, NOP, NOP, {4'd3, 1'b0, 6'd1, 6'd7}, 4'b0000, 1'b0, 32'h0},
        // R8: same dst but slot 1 disabled -> no conflict
        {NOP, NOP, {4'd8, 1'b0, 6'd4, 6'd20}, {4'd0, 1'b0, 6'd2, 6'd20}, 4'b0001, 1'b0, 32'hA000_0002}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one word on the falling edge, return on the next falling edge.
    task automatic step(input logic iss, input logic [67:0] w,
                        input logic ld, input logic [31:0] lv);
        issue = iss; instr = w; limm_load = ld; limm_value = lv;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) src_words[k*32 +: 32] = 32'hA000_0000 | k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", {59'd0, out_en, conflict}, 64'd0);
        check("R1", {out_data[63:0]}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            step(1'b1, VECS[v][104:37], 1'b0, 32'h0);
            check($sformatf("vector %0d", v), {27'd0, out_en, conflict, out_data[31:0]},
                  {27'd0, VECS[v][36:0]});
        end

        // R9: word not issued does nothing, not even a predicate write
        step(1'b0, {NOP, NOP, NOP, {4'd0, 1'b1, 6'd1, 6'd61}}, 1'b0, 32'h0);
        check("R9", {60'd0, out_en}, 64'd0);
        step(1'b1, {NOP, NOP, NOP, {4'd5, 1'b0, 6'd1, 6'd3}}, 1'b0, 32'h0);
        check("R9", {60'd0, out_en}, 64'd0);

        // R5: same-cycle bypass of a fresh long immediate
        step(1'b1, {NOP, NOP, NOP, {4'd0, 1'b0, 6'd63, 6'd1}}, 1'b1, 32'hDEAD_BEEF);
        check("R5", {32'd0, out_data[31:0]}, 64'hDEAD_BEEF);
        // R5: later word reads the stored value, not the unloaded input
        step(1'b1, {NOP, NOP, {4'd0, 1'b0, 6'd63, 6'd2}, NOP}, 1'b0, 32'h1234_5678);
        check("R5", {28'd0, out_en, out_data[63:32]}, {28'd0, 4'b0010, 32'hDEAD_BEEF});

        // R7: write to predicate 0 ignored; guard 0 still fires
        step(1'b1, {NOP, NOP, NOP, {4'd0, 1'b1, 6'd0, 6'd56}}, 1'b0, 32'h0);
        step(1'b1, {NOP, NOP, NOP, {4'd0, 1'b0, 6'd1, 6'd3}}, 1'b0, 32'h0);
        check("R7", {60'd0, out_en}, 64'd1);
        // R2: destination field lands on slot 0 destination output
        check("R2", {58'd0, out_dst[5:0]}, 64'd3);

        // R3: unused source code transports zero
        step(1'b1, {NOP, NOP, NOP, {4'd0, 1'b0, 6'd40, 6'd4}}, 1'b0, 32'h0);
        check("R3", {28'd0, out_en, out_data[31:0]}, {28'd0, 4'b0001, 32'h0});

        // R2: slot 3 position and its output lanes
        step(1'b1, {{4'd0, 1'b0, 6'd7, 6'd33}, NOP, NOP, NOP}, 1'b0, 32'h0);
        check("R2", {22'd0, out_en, out_dst[23:18], out_data[127:96]},
              {22'd0, 4'b1000, 6'd33, 32'hA000_0007});

        // R1: mid-run reset clears outputs
        issue = 1'b1; instr = {NOP, NOP, NOP, {4'd0, 1'b0, 6'd1, 6'd3}}; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", {27'd0, out_en, conflict, out_data[31:0]}, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule